// File: doc/BRIEF.md
# Two-Wire Bus Status Flag Unit

This block watches the already-synchronized clock and data lines of a two-wire serial bus. From them it builds a read-only 4-bit status word that a processor can poll. The block detects start and stop conditions. It counts rising clock edges within each frame. It turns bus conditions and counter values into four flags: bus occupied, start observed, last-data-bit clock reached and acknowledge clock reached.

A mode input chooses between two-wire bus operation and plain serial I/O operation. The two bus-condition flags are meaningful only in two-wire operation. The two clock-position flags follow the clock counter in either mode. A processor can poll the occupied flag to learn whether other devices hold the bus. It can use the acknowledge-clock flag as the window in which an acknowledge bit may be read.

Top module: `twb_status_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls with idle lines, `status_o` reads 4'b0000.
- R2: A start is SDA falling while SCL stays high on two consecutive samples. A stop is SDA rising while SCL stays high. In two-wire mode a start sets bit 0 (occupied) and a stop clears it, one clock after the condition is sampled.
- R3: When `bus_mode_i` is 0 (serial I/O), bits 0 and 1 read 0 on the next clock. They stay 0 while the mode is 0, and after the mode returns to 1 they stay 0 until the next start condition.
- R4: In two-wire mode a start sets bit 1 (start observed). Bit 1 clears when the clock counter reaches FRAME_BITS+1.
- R5: The clock counter goes to 0 on a start condition and increments on each rising SCL edge. From FRAME_BITS+1 the next rising edge moves it to 1. It runs in both modes.
- R6: Bit 2 (acknowledge clock) sets when the counter reaches FRAME_BITS+1 and clears when it reaches 0 or 1.
- R7: Bit 2 does not depend on `bus_mode_i`: it sets at count FRAME_BITS+1 in serial I/O mode as well.
- R8: Bit 3 (last data clock) sets when the counter reaches FRAME_BITS and clears when it reaches FRAME_BITS+1 or 0. Bits 2 and 3 are never both 1.
- R9: SDA changes while SCL is low are neither start nor stop. They leave `status_o` unchanged.
- R10: A repeated start in the middle of a frame returns the counter to 0. It clears bits 2 and 3 and sets bits 0 and 1 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronized bus clock line |
| sda_i | input | 1 | Synchronized bus data line |
| bus_mode_i | input | 1 | 1 = two-wire bus mode, 0 = serial I/O mode |
| status_o | output | 4 | Status word: bit0 occupied, bit1 start observed, bit2 acknowledge clock, bit3 last data clock |

## Verification
The bench builds the unit with the default FRAME_BITS of 8, so the counter runs 0 to 9. A frame of nine clocks followed by a tenth edge is short enough to walk through every counter transition, including the wrap from 9 to 1. At this size every step can be checked against a cycle-accurate model, across repeated starts, data moves while the clock is low, and serial-mode frames. The mode toggles while the bus is held occupied, which shows that the flag stays cleared after the mode returns.

// File: rtl/twb_status_pkg.sv
package twb_status_pkg;

  localparam int unsigned BIT_BUSY   = 0;
  localparam int unsigned BIT_START  = 1;
  localparam int unsigned BIT_NINTH  = 2;
  localparam int unsigned BIT_EIGHTH = 3;
  localparam int unsigned STATUS_W   = 4;

  typedef struct packed {
    logic eighth;
    logic ninth;
    logic start_seen;
    logic busy;
  } twb_flags_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic scl_rise;
  } twb_events_t;

endpackage

// File: rtl/twb_line_watch.sv
module twb_line_watch
  import twb_status_pkg::*;
(
  input  logic        clk,
  input  logic        scl_i,
  input  logic        sda_i,
  output twb_events_t ev_o
);

  logic scl_q;
  logic sda_q;

  // Previous-sample registers follow the lines in every cycle, reset included,
  // so the first cycle after reset compares against real line history.
  always_ff @(posedge clk) begin
    scl_q <= scl_i;
    sda_q <= sda_i;
  end

  always_comb begin
    ev_o.start    = scl_q &  scl_i &  sda_q & ~sda_i;
    ev_o.stop     = scl_q &  scl_i & ~sda_q &  sda_i;
    ev_o.scl_rise = ~scl_q & scl_i;
  end

endmodule

// File: rtl/twb_clock_counter.sv
module twb_clock_counter
  import twb_status_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 8,
  localparam int unsigned LAST_CNT  = FRAME_BITS + 1,
  localparam int unsigned CNT_W     = $clog2(LAST_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  twb_events_t      ev_i,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             cnt_upd_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAST_CNT);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    cnt_nxt_o = cnt_q;
    cnt_upd_o = 1'b0;
    if (ev_i.start) begin
      cnt_nxt_o = '0;
      cnt_upd_o = 1'b1;
    end else if (ev_i.scl_rise) begin
      cnt_upd_o = 1'b1;
      cnt_nxt_o = (cnt_q == CNT_LAST) ? CNT_ONE : cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt_o;
  end

endmodule

// File: rtl/twb_status_flags.sv
module twb_status_flags
  import twb_status_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 8,
  localparam int unsigned LAST_CNT  = FRAME_BITS + 1,
  localparam int unsigned CNT_W     = $clog2(LAST_CNT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_mode_i,
  input  twb_events_t      ev_i,
  input  logic [CNT_W-1:0] cnt_nxt_i,
  input  logic             cnt_upd_i,
  output twb_flags_t       flags_o
);

  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LAST_CNT);
  localparam logic [CNT_W-1:0] CNT_DATA = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  logic at_last;
  logic at_data;
  logic at_low;
  logic at_zero;
  twb_flags_t flags_d;

  assign at_last = cnt_upd_i && (cnt_nxt_i == CNT_LAST);
  assign at_data = cnt_upd_i && (cnt_nxt_i == CNT_DATA);
  assign at_low  = cnt_upd_i && (cnt_nxt_i <= CNT_ONE);
  assign at_zero = cnt_upd_i && (cnt_nxt_i == '0);

  always_comb begin
    flags_d = flags_o;

    // Bus-condition flags: only alive in two-wire mode.
    if (!bus_mode_i) begin
      flags_d.busy       = 1'b0;
      flags_d.start_seen = 1'b0;
    end else begin
      if (ev_i.start)     flags_d.busy = 1'b1;
      else if (ev_i.stop) flags_d.busy = 1'b0;
      if (ev_i.start)     flags_d.start_seen = 1'b1;
      else if (at_last)   flags_d.start_seen = 1'b0;
    end

    // Clock-position flags: follow the counter in any mode.
    if (at_last)     flags_d.ninth = 1'b1;
    else if (at_low) flags_d.ninth = 1'b0;

    if (at_data)                 flags_d.eighth = 1'b1;
    else if (at_last || at_zero) flags_d.eighth = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= flags_d;
  end

endmodule

// File: rtl/twb_status_unit.sv
module twb_status_unit
  import twb_status_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                scl_i,
  input  logic                sda_i,
  input  logic                bus_mode_i,
  output logic [STATUS_W-1:0] status_o
);

  localparam int unsigned LAST_CNT = FRAME_BITS + 1;
  localparam int unsigned CNT_W    = $clog2(LAST_CNT + 1);

  twb_events_t      ev;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_upd;
  twb_flags_t       flags;

  twb_line_watch u_watch (
    .clk   (clk),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev_o  (ev)
  );

  twb_clock_counter #(.FRAME_BITS(FRAME_BITS)) u_count (
    .clk       (clk),
    .rst       (rst),
    .ev_i      (ev),
    .cnt_nxt_o (cnt_nxt),
    .cnt_upd_o (cnt_upd)
  );

  twb_status_flags #(.FRAME_BITS(FRAME_BITS)) u_flags (
    .clk        (clk),
    .rst        (rst),
    .bus_mode_i (bus_mode_i),
    .ev_i       (ev),
    .cnt_nxt_i  (cnt_nxt),
    .cnt_upd_i  (cnt_upd),
    .flags_o    (flags)
  );

  assign status_o = flags;

endmodule

// File: rtl/twb_status_chk.sv
module twb_status_chk (
  input logic       clk,
  input logic       rst,
  input logic       scl_i,
  input logic       sda_i,
  input logic       bus_mode_i,
  input logic [3:0] status_o
);

  // R2
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[0]) |-> ($past(bus_mode_i) && $past(scl_i) && $past(scl_i, 2)
                            && $past(sda_i, 2) && !$past(sda_i)));

  // R3
  serial_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_mode_i |=> (status_o[1:0] == 2'b00));

  // R4
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[1]) |-> status_o[0]);

  // R6
  ninth_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(status_o[2]) |-> ($past(scl_i) && !$past(scl_i, 2)));

  // R8
  eighth_ninth_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(status_o[3] && status_o[2]));

endmodule

bind twb_status_unit twb_status_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .scl_i      (scl_i),
  .sda_i      (sda_i),
  .bus_mode_i (bus_mode_i),
  .status_o   (status_o)
);

// File: tb/test_twb_status_unit.sv
module test_twb_status_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda = 1'b1;
  logic       mode = 1'b1;
  logic [3:0] status;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [3:0] exp;
    string      tag;
  } item_t;

  item_t q[$];

  // Bench model state
  logic m_scl = 1'b1, m_sda = 1'b1;
  int   m_cnt = 0;
  logic m_busy = 0, m_ss = 0, m_s9 = 0, m_s8 = 0;

  always #5 clk = ~clk;

  twb_status_unit i_twb_status_unit (
    .clk        (clk),
    .rst        (rst),
    .scl_i      (scl),
    .sda_i      (sda),
    .bus_mode_i (mode),
    .status_o   (status)
  );

  // Driver: apply one cycle of inputs at the falling edge and predict.
  task automatic step(input logic r, input logic c, input logic d, input logic m, input string tag);
    logic st, sp, rise, upd;
    item_t it;
    @(negedge clk);
    rst = r; scl = c; sda = d; mode = m;
    st   = m_scl && c && m_sda && !d;
    sp   = m_scl && c && !m_sda && d;
    rise = !m_scl && c;
    if (r) begin
      m_cnt = 0; m_busy = 0; m_ss = 0; m_s9 = 0; m_s8 = 0;
    end else begin
      upd = st || rise;
      if (st) m_cnt = 0;
      else if (rise) m_cnt = (m_cnt == 9) ? 1 : m_cnt + 1;
      if (!m) begin m_busy = 0; m_ss = 0; end
      else begin
        if (st) m_busy = 1; else if (sp) m_busy = 0;
        if (st) m_ss = 1; else if (upd && m_cnt == 9) m_ss = 0;
      end
      if (upd && m_cnt == 9) m_s9 = 1; else if (upd && m_cnt <= 1) m_s9 = 0;
      if (upd && m_cnt == 8) m_s8 = 1; else if (upd && (m_cnt == 9 || m_cnt == 0)) m_s8 = 0;
    end
    m_scl = c; m_sda = d;
    it.exp = {m_s8, m_s9, m_ss, m_busy};
    it.tag = tag;
    q.push_back(it);
  endtask

  // Monitor: compare just after the edge that registers the result.
  always @(posedge clk) begin
    item_t it;
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      n_vec++;
      if (status !== it.exp) begin
        n_fail++;
        $display("FAIL %s: status=%b expected=%b", it.tag, status, it.exp);
      end
    end
  end

  task automatic clk_bit(input logic b, input string tag);
    step(0, 0, sda, mode, tag);
    step(0, 0, b, mode, tag);
    step(0, 1, b, mode, tag);
  endtask

  task automatic bus_start(input string tag);
    if (!(scl && sda)) begin
      step(0, 0, sda, mode, tag);
      step(0, 0, 1, mode, tag);
      step(0, 1, 1, mode, tag);
    end
    step(0, 1, 0, mode, tag);
  endtask

  task automatic bus_stop(input string tag);
    step(0, 0, sda, mode, tag);
    step(0, 0, 0, mode, tag);
    step(0, 1, 0, mode, tag);
    step(0, 1, 1, mode, tag);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
  endtask

  initial begin
    // R1: reset state
    repeat (3) step(1, 1, 1, 1, "R1");
    step(0, 1, 1, 1, "R1");
    // R2: start sets occupied and start-observed
    bus_start("R2");
    // R8 / R5: eight clocks with data
    for (int i = 0; i < 8; i++) clk_bit(i[0], (i == 7) ? "R8" : "R5");
    // R4: ninth clock clears start-observed, sets acknowledge flag
    clk_bit(0, "R4");
    // R6: tenth edge wraps counter to 1
    clk_bit(1, "R6");
    // R9: data moves while SCL low
    step(0, 0, 1, 1, "R9");
    step(0, 0, 0, 1, "R9");
    step(0, 0, 1, 1, "R9");
    step(0, 0, 0, 1, "R9");
    // Second frame, then repeated start mid-frame
    for (int i = 0; i < 8; i++) clk_bit(1, "R5");
    bus_start("R10");
    for (int i = 0; i < 9; i++) clk_bit(i[1], "R10");
    clk_bit(1, "R10");
    for (int i = 0; i < 3; i++) clk_bit(0, "R10");
    bus_start("R10");
    // R3: mode toggled while occupied
    step(0, 1, 0, 0, "R3");
    step(0, 1, 0, 0, "R3");
    step(0, 1, 0, 1, "R3");
    clk_bit(1, "R3");
    step(0, 1, 1, 1, "R3");
    bus_start("R3");
    // R7: serial mode frame reaches the ninth clock
    step(0, scl, sda, 0, "R7");
    for (int i = 0; i < 9; i++) clk_bit(i[0], "R7");
    clk_bit(0, "R7");
    bus_start("R7");
    step(0, scl, sda, 1, "R2");
    bus_start("R2");
    // R2: stop clears occupied
    bus_stop("R2");
    repeat (2) step(0, 1, 1, 1, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected end of stimulus");
      summary();
      $finish;
    end
  end

endmodule